// File: doc/BRIEF.md
# Processor Interrupt Acceptance Unit

This block is the processor-side gate for requests arriving from an external interrupt controller. Each cycle it looks at the request bundle: a valid flag, a 6-bit requested level, a requested register set and a nonmaskable flag. It compares the bundle with the processor's live status and raises a combinational accept signal when the request may be taken. The core pipeline answers with a take strobe. On the clock edge where that strobe meets an accepted request, the unit updates its status and keeps a copy of the status as it was just before.

The status holds a current level, a maskable-enable bit, the current register set, a register-set interrupt-enable bit and a nonmaskable-active flag. A return strobe puts the saved copy back into the live status. A configuration input chooses whether maskable interrupts stay enabled after entry. Fetching the handler and jumping to the vector are left to the pipeline.

Top module: `irq_accept_unit`

## Requirements
- R1: A nonmaskable request (req_nmi=1) is accepted unless nmi_active_o is 1; the register-set rule of R3 still applies.
- R2: A maskable request (req_nmi=0) is accepted only when pie_o is 1 and req_level is strictly greater than cur_level_o.
- R3: With shadow sets enabled (SHADOW_EN=1), a request is accepted only if req_rset differs from cur_rset_o or rsie_o is 1.
- R4: accept_o is 0 whenever req_valid is 0. A take strobe without accept_o, or with req_valid low, leaves every status output unchanged.
- R5: Taking a maskable request clears pie_o when cfg_keep_en is 0 and leaves pie_o at 1 when cfg_keep_en is 1.
- R6: Taking a nonmaskable request sets nmi_active_o and clears pie_o, whatever the value of cfg_keep_en.
- R7: Taking any request loads cur_level_o with req_level and cur_rset_o with req_rset, visible one cycle after the take edge.
- R8: Taking a request saves the whole status as it was before that edge. A later ret_strobe restores that saved copy, which also clears nmi_active_o.
- R9: When take (with accept) and ret_strobe fall on the same edge, the take update wins and the return is ignored.
- R10: After a synchronous active-low reset: level 0, register set 0, nmi_active 0, pie = RST_PIE (default 1), rsie = RST_RSIE (default 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request bundle present |
| req_level | input | 6 | Requested interrupt level |
| req_rset | input | 2 | Requested register set |
| req_nmi | input | 1 | Request is nonmaskable |
| take_strobe | input | 1 | Pipeline takes the exception this edge |
| ret_strobe | input | 1 | Return from exception this edge |
| cfg_keep_en | input | 1 | Keep maskable interrupts enabled on entry |
| accept_o | output | 1 | Combinational take decision |
| cur_level_o | output | 6 | Current interrupt level |
| pie_o | output | 1 | Maskable interrupts enabled |
| cur_rset_o | output | 2 | Current register set |
| rsie_o | output | 1 | Register-set interrupt enable |
| nmi_active_o | output | 1 | A nonmaskable interrupt is in progress |

## Verification
Every cycle, the assertions check that an accept never goes against the NMI-in-progress rule, the strict level comparison or the register-set conflict rule. They also check that a taken request loads its level and set, that the saved copy equals the previous status, and that a return restores it. Some behaviour only the bench's scenarios can show. These are the sequences: the keep-enabled bit changing what entry does to the enable bit, a second NMI being refused, a take and a return on the same edge, and nested entries overwriting the single saved copy. The bench's reference model checks accept and every status output on every cycle of these scenarios.

// File: rtl/irq_accept_pkg.sv
// Shared widths and the status record for the interrupt acceptance unit.
// Assumes a single saved copy of status (one nesting level of restore).
package irq_accept_pkg;
    parameter int LVL_W = 6;
    parameter int RS_W  = 2;

    typedef struct packed {
        logic [LVL_W-1:0] lvl;
        logic             pie;
        logic [RS_W-1:0]  rset;
        logic             rsie;
        logic             nmi;
    } irq_status_t;
endpackage

// File: rtl/irq_accept_decide.sv
// Combinational take decision: the NMI-in-progress check, the strict level
// comparison and (when SHADOW_EN=1) the register-set conflict rule.
// Assumes sts is the registered live status.
module irq_accept_decide
    import irq_accept_pkg::*;
#(
    parameter bit SHADOW_EN = 1'b1
) (
    input  logic             req_valid,
    input  logic [LVL_W-1:0] req_level,
    input  logic [RS_W-1:0]  req_rset,
    input  logic             req_nmi,
    input  irq_status_t      sts,
    output logic             accept
);
    logic rs_ok;
    logic nmi_ok;
    logic mask_ok;

    generate
        if (SHADOW_EN) begin : g_shadow
            // Register-set rule: a different set, or nesting on a set explicitly allowed
            always_comb rs_ok = (req_rset != sts.rset) || sts.rsie;
        end else begin : g_flat
            // No shadow sets: the set field never blocks a request
            always_comb rs_ok = 1'b1;
        end
    endgenerate

    // Per-class eligibility and the combined decision
    always_comb begin
        nmi_ok  = req_nmi && !sts.nmi;
        mask_ok = !req_nmi && sts.pie && (req_level > sts.lvl);
        accept  = req_valid && rs_ok && (nmi_ok || mask_ok);
    end
endmodule

// File: rtl/irq_status_regs.sv
// Live and saved status registers. They update on an accepted take, or are
// restored from the saved copy on return; take has priority over return.
// Assumes accept comes from irq_accept_decide on the same status.
module irq_status_regs
    import irq_accept_pkg::*;
#(
    parameter bit RST_PIE  = 1'b1,
    parameter bit RST_RSIE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             take_strobe,
    input  logic             ret_strobe,
    input  logic             cfg_keep_en,
    input  logic [LVL_W-1:0] req_level,
    input  logic [RS_W-1:0]  req_rset,
    input  logic             req_nmi,
    output irq_status_t      sts,
    output irq_status_t      saved
);
    irq_status_t rst_val;
    irq_status_t entry_val;
    logic        do_take;

    // Reset image and the status that an accepted take installs
    always_comb begin
        rst_val      = '0;
        rst_val.pie  = RST_PIE;
        rst_val.rsie = RST_RSIE;
        do_take      = take_strobe && accept;
        entry_val      = sts;
        entry_val.lvl  = req_level;
        entry_val.rset = req_rset;
        entry_val.nmi  = sts.nmi || req_nmi;
        entry_val.pie  = req_nmi ? 1'b0 : (cfg_keep_en ? sts.pie : 1'b0);
    end

    // Status register update: take wins over return
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts   <= rst_val;
            saved <= rst_val;
        end else if (do_take) begin
            sts   <= entry_val;
            saved <= sts;
        end else if (ret_strobe) begin
            sts   <= saved;
        end
    end

    a_r7_level_load: assert property (@(posedge clk) disable iff (!rst_n)
        do_take |=> (sts.lvl == $past(req_level)) && (sts.rset == $past(req_rset)));
    a_r8_saved_copy: assert property (@(posedge clk) disable iff (!rst_n)
        do_take |=> saved == $past(sts));
    a_r8_restore: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_strobe && !do_take) |=> sts == $past(saved));
    a_r5_pie_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (do_take && !cfg_keep_en) |=> !sts.pie);
    a_r6_nmi_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (do_take && req_nmi) |=> (sts.nmi && !sts.pie));
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!do_take && !ret_strobe) |=> $stable(sts));
endmodule

// File: rtl/irq_accept_unit.sv
// Top of the processor interrupt acceptance unit: decision logic plus status
// registers. Assumes the pipeline asserts take_strobe only when it acts on
// accept_o in the same cycle.
module irq_accept_unit
    import irq_accept_pkg::*;
#(
    parameter bit SHADOW_EN = 1'b1,
    parameter bit RST_PIE   = 1'b1,
    parameter bit RST_RSIE  = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [LVL_W-1:0] req_level,
    input  logic [RS_W-1:0]  req_rset,
    input  logic             req_nmi,
    input  logic             take_strobe,
    input  logic             ret_strobe,
    input  logic             cfg_keep_en,
    output logic             accept_o,
    output logic [LVL_W-1:0] cur_level_o,
    output logic             pie_o,
    output logic [RS_W-1:0]  cur_rset_o,
    output logic             rsie_o,
    output logic             nmi_active_o
);
    irq_status_t sts;
    irq_status_t saved;
    logic        accept;

    irq_accept_decide #(.SHADOW_EN(SHADOW_EN)) u_decide (
        .req_valid (req_valid),
        .req_level (req_level),
        .req_rset  (req_rset),
        .req_nmi   (req_nmi),
        .sts       (sts),
        .accept    (accept)
    );

    irq_status_regs #(.RST_PIE(RST_PIE), .RST_RSIE(RST_RSIE)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .take_strobe (take_strobe),
        .ret_strobe  (ret_strobe),
        .cfg_keep_en (cfg_keep_en),
        .req_level   (req_level),
        .req_rset    (req_rset),
        .req_nmi     (req_nmi),
        .sts         (sts),
        .saved       (saved)
    );

    // Drive the status fields out to the ports
    always_comb begin
        accept_o     = accept;
        cur_level_o  = sts.lvl;
        pie_o        = sts.pie;
        cur_rset_o   = sts.rset;
        rsie_o       = sts.rsie;
        nmi_active_o = sts.nmi;
    end

    a_r1_nmi_block: assert property (@(posedge clk) disable iff (!rst_n)
        (req_nmi && nmi_active_o) |-> !accept_o);
    a_r2_level_gt: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o && !req_nmi) |-> (pie_o && (req_level > cur_level_o)));
    a_r3_rset_rule: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o && SHADOW_EN && !rsie_o) |-> (req_rset != cur_rset_o));
    a_r4_valid_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !accept_o);
endmodule

// File: tb/sim_irq_accept_unit.sv
module sim_irq_accept_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_nmi = 1'b0;
    logic [5:0] req_level = '0;
    logic [1:0] req_rset = '0;
    logic       take_strobe = 1'b0, ret_strobe = 1'b0, cfg_keep_en = 1'b0;
    logic       accept_o, pie_o, rsie_o, nmi_active_o;
    logic [5:0] cur_level_o;
    logic [1:0] cur_rset_o;

    int tests = 0, fails = 0;
    bit done = 0;

    // reference state
    int m_lvl, m_pie, m_rs, m_rsie, m_nmi;
    int s_lvl, s_pie, s_rs, s_rsie, s_nmi;

    always #5 clk = ~clk;

    irq_accept_unit u0 (.*);

    task automatic chk(string req, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_status(string req);
        chk(req, "level", cur_level_o, m_lvl);
        chk(req, "pie", pie_o, m_pie);
        chk(req, "rset", cur_rset_o, m_rs);
        chk(req, "rsie", rsie_o, m_rsie);
        chk(req, "nmi_active", nmi_active_o, m_nmi);
    endtask

    task automatic step(string req, bit v, int lvl, int rs, bit nmi,
                        bit take, bit ret, bit keep);
        int acc;
        bit rs_ok;
        @(negedge clk);
        check_status(req);
        req_valid = v; req_level = lvl[5:0]; req_rset = rs[1:0]; req_nmi = nmi;
        take_strobe = take; ret_strobe = ret; cfg_keep_en = keep;
        #1;
        rs_ok = (rs != m_rs) || (m_rsie != 0);
        acc = (v && rs_ok && (nmi ? (m_nmi == 0) : (m_pie != 0 && lvl > m_lvl))) ? 1 : 0;
        chk(req, "accept", accept_o, acc);
        if (take && acc != 0) begin
            s_lvl = m_lvl; s_pie = m_pie; s_rs = m_rs; s_rsie = m_rsie; s_nmi = m_nmi;
            m_lvl = lvl; m_rs = rs;
            if (nmi) begin m_nmi = 1; m_pie = 0; end
            else if (!keep) m_pie = 0;
        end else if (ret) begin
            m_lvl = s_lvl; m_pie = s_pie; m_rs = s_rs; m_rsie = s_rsie; m_nmi = s_nmi;
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        m_lvl = 0; m_pie = 1; m_rs = 0; m_rsie = 0; m_nmi = 0;
        s_lvl = 0; s_pie = 1; s_rs = 0; s_rsie = 0; s_nmi = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state checked in the first step
        step("R10", 0, 0, 0, 0, 0, 0, 0);
        step("R4", 0, 5, 1, 0, 1, 0, 0);   // no valid: take ignored
        step("R4", 0, 5, 1, 1, 1, 0, 0);   // no valid NMI: ignored
        step("R2", 1, 0, 1, 0, 1, 0, 0);   // level equal to 0: refused
        step("R3", 1, 5, 0, 0, 1, 0, 0);   // same set with rsie=0: refused
        step("R7", 1, 5, 1, 0, 1, 0, 0);   // taken, keep=0
        step("R5", 1, 9, 2, 0, 1, 0, 0);   // pie now 0: refused
        step("R8", 0, 0, 0, 0, 0, 1, 0);   // return restores
        step("R5", 1, 3, 1, 0, 1, 0, 1);   // taken, keep=1 retains pie
        step("R2", 1, 3, 2, 0, 1, 0, 1);   // equal level: refused
        step("R2", 1, 4, 2, 0, 0, 0, 1);   // accepted but not taken
        step("R4", 1, 4, 2, 0, 0, 0, 1);   // state must be unchanged
        step("R7", 1, 4, 2, 0, 1, 0, 1);   // nested take overwrites saved
        step("R6", 1, 1, 0, 1, 1, 0, 1);   // NMI taken despite keep=1
        step("R1", 1, 9, 3, 1, 1, 0, 1);   // second NMI refused
        step("R2", 1, 60, 3, 0, 1, 0, 1);  // maskable refused during NMI
        step("R8", 0, 0, 0, 0, 0, 1, 0);   // return clears nmi_active
        step("R3", 1, 7, 2, 1, 1, 0, 0);   // NMI to same set refused
        step("R9", 1, 7, 3, 1, 1, 1, 0);   // take and return together
        step("R9", 0, 0, 0, 0, 0, 0, 0);
        step("R8", 0, 0, 0, 0, 0, 1, 0);
        step("R1", 1, 0, 0, 1, 0, 0, 0);   // NMI eligible again
        step("R8", 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        check_status("R8");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule